// File: doc/BRIEF.md
# Byte-Serial Configuration Stream Loader

This block lets a host processor feed a configuration bitstream into an attached programmable device in passive-serial fashion, one byte per bus write. The host sees two byte-wide locations on a small write/read port. A data location takes the next bitstream byte. A control/status location holds the target-reset request, a finishing-phase control, a busy handshake, a sticky overrun flag and a load-complete flag. Each accepted byte is shifted out on a serial data line, one bit per serial-clock period. The serial clock is derived from the system clock by a programmable half-period divider.

A load runs as follows. Software writes the reset bit to 0 and then to 1. The block keeps the target reset pin low for a minimum hold time, and after release it keeps busy set for a settling time. Software then streams bytes, polling busy before each write. At the end it sets the finishing-phase bit, which produces free-running trailing clocks with data held high. It later clears that bit by read-modify-write and reads the load-complete flag. That flag is the synchronised done input qualified by the synchronised status input.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset the control/status location reads 0x01 (busy set, every other bit 0), `tgt_cfg_n` and `tgt_dclk` are 0, `tgt_data` is 1, and the data location reads 0x00.
- R2: Control bit 1 is the release request. While it is 0, `tgt_cfg_n` is driven low no later than the second clock edge after the write. After a request to release, `tgt_cfg_n` stays low for at least `RST_HOLD_CYC` cycles in total before it rises.
- R3: Once `tgt_cfg_n` has risen, busy (control bit 0) reads 1 for exactly `SETTLE_CYC` cycles before it first reads 0.
- R4: An accepted byte is sent least-significant bit first as 8 rising edges of `tgt_dclk`. Each high phase lasts `CLK_HALF` cycles, and `tgt_data` changes only while `tgt_dclk` is low.
- R5: A data write made while busy reads 0 is accepted. Busy reads 1 from the cycle after the write and falls to 0 exactly 16×`CLK_HALF` cycles after the write edge.
- R6: A data write made while busy reads 1 is ignored, so none of its bits reach `tgt_data`, and it sets the overrun flag (control bit 4). The flag stays set through control writes that keep bit 1 at 1, and is cleared by a control write with bit 1 at 0.
- R7: The load-complete flag (control bit 2) is `tgt_done` AND `tgt_status`, each passed through a two-flop synchroniser. A change that completes the AND is visible after the second clock edge and not after the first.
- R8: While control bit 3 is 1, the target is released and no byte is being shifted, `tgt_dclk` toggles with the same half period and `tgt_data` is held at 1. After bit 3 is cleared, `tgt_dclk` returns to 0 within `CLK_HALF`+1 cycles and stays there.
- R9: Control bits 1 and 3 read back as last written, so read-modify-write preserves them.
- R10: Asserting the target reset while a byte is being shifted aborts it: `tgt_dclk` is 0 from the edge after `tgt_cfg_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Location select: 0 data, 1 control/status |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected location (combinational) |
| tgt_cfg_n | output | 1 | Target configuration reset, low = held in reset |
| tgt_dclk | output | 1 | Serial configuration clock |
| tgt_data | output | 1 | Serial configuration data |
| tgt_status | input | 1 | Target status line (asynchronous) |
| tgt_done | input | 1 | Target done line (asynchronous) |

## Verification
Every result has a fixed latency from its stimulus. Overrun and busy follow a data write on the next edge. Busy falls 16×`CLK_HALF` edges after an accepted write. The target reset falls two edges after a control write that clears bit 1, and the serial clock is stopped one edge after that. Load-complete follows an input change on the second edge. The bench drives inputs and samples outputs on the falling clock edge, and counts falling edges between the stimulus and the change. A scoreboard queue holds the expected bits of each accepted byte, and a monitor pops and compares one entry on every rising serial-clock edge, so an ignored byte shows up as an unexpected bit.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
   // location decode
   localparam logic ADDR_DATA = 1'b0;
   localparam logic ADDR_CTRL = 1'b1;
   // control/status bit positions (software relies on these)
   localparam int unsigned B_BUSY = 0;
   localparam int unsigned B_REL  = 1;
   localparam int unsigned B_LDOK = 2;
   localparam int unsigned B_LOAD = 3;
   localparam int unsigned B_OVR  = 4;

   typedef struct packed {
      logic [2:0] rsv;
      logic       ovr;
      logic       load;
      logic       ldok;
      logic       rel;
      logic       busy;
   } ctrl_view_t;
endpackage

// File: rtl/cfg_ld_sync.sv
module cfg_ld_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_ld_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_ld_rstseq.sv
module cfg_ld_rstseq #(
   parameter int unsigned HOLD_CYC   = 1500,
   parameter int unsigned SETTLE_CYC = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rel_req,
   output logic cfg_n,
   output logic ready
);
   localparam int unsigned HW = $clog2(HOLD_CYC + 1);
   localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
   localparam logic [HW-1:0] HOLD_MAX   = HW'(HOLD_CYC);
   localparam logic [SW-1:0] SETTLE_MAX = SW'(SETTLE_CYC);

   logic [HW-1:0] hold_cnt;
   logic [SW-1:0] settle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_n      <= 1'b0;
         hold_cnt   <= '0;
         settle_cnt <= '0;
      end else begin
         if (!rel_req)
            cfg_n <= 1'b0;
         else if (!cfg_n && hold_cnt == HOLD_MAX)
            cfg_n <= 1'b1;

         if (cfg_n)
            hold_cnt <= '0;
         else if (hold_cnt != HOLD_MAX)
            hold_cnt <= hold_cnt + 1'b1;

         if (!cfg_n)
            settle_cnt <= '0;
         else if (settle_cnt != SETTLE_MAX)
            settle_cnt <= settle_cnt + 1'b1;
      end
   end

   assign ready = cfg_n && (settle_cnt == SETTLE_MAX);
endmodule

// File: rtl/cfg_ld_shifter.sv
module cfg_ld_shifter #(
   parameter int unsigned HALF      = 25,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       abort,
   input  logic       load,
   input  logic [7:0] din,
   input  logic       trail_en,
   output logic       shifting,
   output logic       dclk,
   output logic       dout
);
   localparam int unsigned DW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [DW-1:0] DIV_LAST = DW'(HALF - 1);

   logic [DW-1:0] div_cnt;
   logic [2:0]    bit_idx;
   logic [7:0]    sreg;
   logic [7:0]    sreg_nxt;
   logic          first_bit;
   logic          next_bit;

   if (LSB_FIRST) begin : g_lsb
      assign sreg_nxt  = {1'b0, sreg[7:1]};
      assign first_bit = din[0];
      assign next_bit  = sreg[1];
   end else begin : g_msb
      assign sreg_nxt  = {sreg[6:0], 1'b0};
      assign first_bit = din[7];
      assign next_bit  = sreg[6];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shifting <= 1'b0;
         dclk     <= 1'b0;
         dout     <= 1'b1;
         div_cnt  <= '0;
         bit_idx  <= '0;
         sreg     <= '0;
      end else if (abort) begin
         shifting <= 1'b0;
         dclk     <= 1'b0;
         dout     <= 1'b1;
         div_cnt  <= '0;
      end else if (load) begin
         shifting <= 1'b1;
         sreg     <= din;
         bit_idx  <= '0;
         div_cnt  <= '0;
         dclk     <= 1'b0;
         dout     <= first_bit;
      end else if (shifting || trail_en || dclk) begin
         if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            if (!dclk) begin
               dclk <= 1'b1;
            end else begin
               dclk <= 1'b0;
               if (shifting) begin
                  if (bit_idx == 3'd7) begin
                     shifting <= 1'b0;
                     dout     <= 1'b1;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     sreg    <= sreg_nxt;
                     dout    <= next_bit;
                  end
               end else begin
                  dout <= 1'b1;
               end
            end
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end else begin
         div_cnt <= '0;
      end
   end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
   import cfg_ld_pkg::*;
#(
   parameter int unsigned CLK_HALF     = 25,
   parameter int unsigned RST_HOLD_CYC = 1500,
   parameter int unsigned SETTLE_CYC   = 4000,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          LSB_FIRST    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_addr,
   input  logic       bus_wr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       tgt_cfg_n,
   output logic       tgt_dclk,
   output logic       tgt_data,
   input  logic       tgt_status,
   input  logic       tgt_done
);
   if (CLK_HALF < 1) begin : g_bad_half
      $error("cfg_stream_loader: CLK_HALF must be at least 1");
   end
   if (RST_HOLD_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_timing
      $error("cfg_stream_loader: hold and settle counts must be at least 1");
   end

   logic       rel_q, load_q, ovr_q;
   logic       seq_ready, shifting;
   logic       busy_w, wr_data, wr_ctrl, accept;
   logic [1:0] sync_q;
   logic       ldok;
   ctrl_view_t view;

   assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
   assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
   assign busy_w  = !seq_ready || shifting || tgt_dclk;
   assign accept  = wr_data && !busy_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_q  <= 1'b0;
         load_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            rel_q  <= bus_wdata[B_REL];
            load_q <= bus_wdata[B_LOAD];
         end
         if (wr_ctrl && !bus_wdata[B_REL])
            ovr_q <= 1'b0;
         else if (wr_data && busy_w)
            ovr_q <= 1'b1;
      end
   end

   cfg_ld_rstseq #(
      .HOLD_CYC  (RST_HOLD_CYC),
      .SETTLE_CYC(SETTLE_CYC)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .rel_req(rel_q),
      .cfg_n  (tgt_cfg_n),
      .ready  (seq_ready)
   );

   cfg_ld_shifter #(
      .HALF     (CLK_HALF),
      .LSB_FIRST(LSB_FIRST)
   ) u_shf (
      .clk     (clk),
      .rst_n   (rst_n),
      .abort   (!tgt_cfg_n),
      .load    (accept),
      .din     (bus_wdata),
      .trail_en(load_q && tgt_cfg_n),
      .shifting(shifting),
      .dclk    (tgt_dclk),
      .dout    (tgt_data)
   );

   cfg_ld_sync #(
      .STAGES(SYNC_STAGES),
      .W     (2)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({tgt_status, tgt_done}),
      .q    (sync_q)
   );

   assign ldok = sync_q[0] && sync_q[1];

   always_comb begin
      view      = '0;
      view.busy = busy_w;
      view.rel  = rel_q;
      view.ldok = ldok;
      view.load = load_q;
      view.ovr  = ovr_q;
   end

   assign bus_rdata = (bus_addr == ADDR_CTRL) ? view : 8'h00;
endmodule

// File: rtl/cfg_ld_chk.sv
module cfg_ld_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_addr,
   input logic bus_wr,
   input logic wr_rel,
   input logic busy,
   input logic ovr,
   input logic tgt_cfg_n,
   input logic tgt_dclk,
   input logic tgt_data
);
   // R6
   ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && busy) |=> ovr);

   // R5
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && !busy) |=> busy);

   // R2
   reset_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr && !wr_rel) |=> ##1 !tgt_cfg_n);

   // R4
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_dclk |-> $stable(tgt_data));

   // R10
   abort_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_cfg_n |=> !tgt_dclk);
endmodule

bind cfg_stream_loader cfg_ld_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wr   (bus_wr),
   .wr_rel   (bus_wdata[1]),
   .busy     (busy_w),
   .ovr      (ovr_q),
   .tgt_cfg_n(tgt_cfg_n),
   .tgt_dclk (tgt_dclk),
   .tgt_data (tgt_data)
);

// File: tb/sim_cfg_stream_loader.sv
`timescale 1ns/1ps
module sim_cfg_stream_loader;
   localparam int HALF   = 2;
   localparam int HOLD   = 20;
   localparam int SETTLE = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b1;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       tgt_cfg_n, tgt_dclk, tgt_data;
   logic       tgt_status = 1'b0;
   logic       tgt_done = 1'b0;

   int  n_run = 0;
   int  n_fail = 0;
   bit  mon_en = 1'b0;
   logic exp_q[$];
   int  lo_run = 0;
   int  lo_last = 0;
   int  hi_run = 0;

   always #10 clk = ~clk;

   cfg_stream_loader #(
      .CLK_HALF(HALF), .RST_HOLD_CYC(HOLD), .SETTLE_CYC(SETTLE)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_cfg_n(tgt_cfg_n),
      .tgt_dclk(tgt_dclk), .tgt_data(tgt_data), .tgt_status(tgt_status),
      .tgt_done(tgt_done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 1'b1;
      #1;
   endtask

   task automatic rd_ctrl(output logic [7:0] v);
      @(negedge clk);
      bus_addr = 1'b1;
      #1 v = bus_rdata;
   endtask

   // driver side of the scoreboard: expected serial bits, LSB first
   task automatic send_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
      wr(1'b0, b);
   endtask

   // counts falling edges while busy reads 1 (call right after wr)
   task automatic busy_len(output int n);
      n = 0;
      while (bus_rdata[0] && n < 2000) begin
         n++;
         @(negedge clk); #1;
      end
   endtask

   // monitor side: pop and compare on every serial rising edge (R4)
   always @(posedge tgt_dclk) begin
      if (mon_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R4/R6 unexpected serial bit", int'(tgt_data), -1);
         end else begin
            logic e;
            e = exp_q.pop_front();
            check(tgt_data == e, "R4 serial bit", int'(tgt_data), int'(e));
         end
      end
   end

   // low-run of target reset and high-phase length of the serial clock
   always @(negedge clk) begin
      if (!rst_n) begin
         lo_run = 0;
      end else if (!tgt_cfg_n) begin
         lo_run++;
      end else if (lo_run != 0) begin
         lo_last = lo_run;
         lo_run = 0;
      end
      if (tgt_dclk) begin
         hi_run++;
      end else if (hi_run != 0) begin
         if (mon_en) check(hi_run == HALF, "R4 high phase length", hi_run, HALF);
         hi_run = 0;
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1-all actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      check(bus_rdata == 8'h01, "R1 ctrl reset value", bus_rdata, 8'h01);
      check(!tgt_cfg_n && !tgt_dclk && tgt_data, "R1 pin reset state",
            {tgt_cfg_n, tgt_dclk, tgt_data}, 3'b001);
      bus_addr = 1'b0; #1;
      check(bus_rdata == 8'h00, "R1 data location reads zero", bus_rdata, 0);
      bus_addr = 1'b1;

      // R2: early release request, reset must still be held
      wr(1'b1, 8'h02);
      n = 0;
      while (!tgt_cfg_n && n < 500) begin n++; @(negedge clk); #1; end
      check(tgt_cfg_n, "R2 target released", int'(tgt_cfg_n), 1);
      check(lo_last >= HOLD, "R2 reset low time", lo_last, HOLD);

      // R3: settle window
      n = 0;
      while (bus_rdata[0] && n < 500) begin n++; @(negedge clk); #1; end
      check(n == SETTLE, "R3 settle cycles", n, SETTLE);

      // R4 / R5: several patterns
      mon_en = 1'b1;
      foreach (v[i]) ;
      begin
         logic [7:0] pats [5];
         pats = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00};
         foreach (pats[k]) begin
            send_byte(pats[k]);
            busy_len(n);
            check(n == 16*HALF, "R5 busy duration", n, 16*HALF);
            check(exp_q.size() == 0, "R4 all bits sent", exp_q.size(), 0);
         end
      end

      // R6: write while busy is ignored, overrun sticky
      send_byte(8'h3C);
      wr(1'b0, 8'hC3);
      busy_len(n);
      check(exp_q.size() == 0, "R6 ignored byte left no bits", exp_q.size(), 0);
      rd_ctrl(v);
      check(v[4] == 1'b1, "R6 overrun set", v[4], 1);
      wr(1'b1, 8'h02);
      rd_ctrl(v);
      check(v[4] == 1'b1, "R6 overrun sticky", v[4], 1);
      mon_en = 1'b0;

      // R7: synchronised load-complete
      @(negedge clk); tgt_done = 1'b1;
      repeat (3) @(negedge clk); #1;
      check(bus_rdata[2] == 1'b0, "R7 done without status", bus_rdata[2], 0);
      tgt_status = 1'b1;
      @(negedge clk); #1;
      check(bus_rdata[2] == 1'b0, "R7 not after first edge", bus_rdata[2], 0);
      @(negedge clk); #1;
      check(bus_rdata[2] == 1'b1, "R7 set after second edge", bus_rdata[2], 1);

      // R8 / R9: trailing clocks during finishing phase
      wr(1'b1, 8'h0A);
      begin
         int rises = 0, bad = 0;
         logic prev = tgt_dclk;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk); #1;
            if (tgt_dclk && !prev) begin
               rises++;
               if (!tgt_data) bad++;
            end
            prev = tgt_dclk;
         end
         check(rises >= 8, "R8 trailing clocks run", rises, 10);
         check(bad == 0, "R8 data high during trailing", bad, 0);
      end
      rd_ctrl(v);
      check((v & 8'h0E) == 8'h0E, "R9 readback bits 1 and 3", v & 8'h0E, 8'h0E);
      wr(1'b1, v & ~8'h08);
      repeat (HALF + 1) @(negedge clk);
      begin
         int hi = 0;
         for (int c = 0; c < 20; c++) begin
            @(negedge clk); #1;
            if (tgt_dclk) hi++;
         end
         check(hi == 0, "R8 clock stopped after clear", hi, 0);
      end
      rd_ctrl(v);
      check((v & 8'h0A) == 8'h02, "R9 readback after RMW", v & 8'h0A, 8'h02);

      // R10 / R2 / R6: reset during shift
      send_byte(8'h5A);
      repeat (5) @(negedge clk);
      wr(1'b1, 8'h00);
      @(negedge clk); #1;
      check(!tgt_cfg_n, "R2 reset driven after write", int'(tgt_cfg_n), 0);
      @(negedge clk); #1;
      check(!tgt_dclk, "R10 clock stopped on abort", int'(tgt_dclk), 0);
      repeat (6) @(negedge clk); #1;
      check(!tgt_dclk, "R10 clock stays low", int'(tgt_dclk), 0);
      rd_ctrl(v);
      check(v[4] == 1'b0 && v[0] == 1'b1, "R6 overrun cleared, busy in reset",
            {v[4], v[0]}, 2'b01);
      exp_q.delete();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule